// File: doc/BRIEF.md
# Trigger and Gate Pacing Controller

This block decides, one clock at a time, whether pacing events may become conversion-start strobes for an analog-to-digital converter. One shared external pin serves three roles, chosen by a small control word. It can be a level gate that pauses and resumes acquisition. It can be a one-shot start edge of either polarity. With the function disabled, it is just a plain digital input whose synchronised level is brought out for reading.

Pacing events come from one of two places: an internal pacer tick, or rising edges on a second external pin. The second pin has its own two-flop synchroniser. Either pacing source works with the gate function and with the trigger function. A trigger, once seen, keeps acquisition running until a disarm strobe arrives or until a control write changes any of the three mode bits.

Top module: `acq_pace_gate`

## Requirements
- R1: While reset is held, and after it is released, `conv_start` is 0 and the control word is 0. A control word of 0 means trigger/gate disabled and internal pacing, so `acq_run` reads 1.
- R2: With enable (control bit 0) at 0, `acq_run` stays 1 whatever the shared pin does. `tg_din` shows the pin level two clocks after it changes.
- R3: With enable 1 and select (bit 1) 0, the pin is a level gate. `acq_run` equals the synchronised pin level when polarity (bit 2) is 0, and its inverse when polarity is 1. Pacing resumes when the gate returns, with no re-arm.
- R4: With enable 1 and select 1, an active edge starts acquisition. The active edge is rising when polarity is 0 and falling when polarity is 1. `acq_run` rises in the clock after the synchronised edge is detected. Further pin activity is then ignored.
- R5: A disarm strobe clears a started trigger. So does a control write whose bits [2:0] differ from the current ones. Either clear beats an active edge detected in the same clock. A write of unchanged bits [2:0] leaves the trigger state alone.
- R6: `conv_start` is one clock wide. It is 1 only in the clock after a pacing event that found `acq_run` at 1.
- R7: Control bit 3 picks the pacing source. At 0, `pacer_tick` paces and the external pacing pin is ignored. At 1, each synchronised rising edge of `xpace_pin` paces and `pacer_tick` is ignored.
- R8: A level change on either external pin reaches detection logic after two synchroniser flops. An edge is found by comparing that synchronised sample with the one from the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 4 | Control word: bit0 enable, bit1 select, bit2 polarity, bit3 external pacing |
| disarm | input | 1 | Clears a started trigger |
| tg_pin | input | 1 | Shared trigger/gate/digital input pin (asynchronous) |
| xpace_pin | input | 1 | External pacing pin (asynchronous) |
| pacer_tick | input | 1 | Internal pacer tick, one clock wide |
| tg_din | output | 1 | Synchronised level of the shared pin |
| conv_start | output | 1 | Conversion-start strobe |
| acq_run | output | 1 | Acquisition allowed in this clock |

## Verification
Two things can land in the same clock: a trigger edge being detected, and a disarm strobe or mode-changing write being applied. The bench provokes this by raising the pin and timing the disarm, and separately a write, so that each hits exactly the clock in which the synchronised edge appears. The outcome is judged by `acq_run` staying 0 and no strobe following. A second coincidence is a pacing event in the same clock as the trigger edge. The bench expects no strobe from that event, because the trigger only takes effect in the next clock.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int CFG_W = 4;

  // bit3 xsel, bit2 pol, bit1 sel, bit0 en
  typedef struct packed {
    logic xsel;
    logic pol;
    logic sel;
    logic en;
  } pg_cfg_t;

  function automatic logic act_edge(input pg_cfg_t c, input logic rise, input logic fall);
    return c.pol ? fall : rise;
  endfunction

  function automatic logic run_ok(input pg_cfg_t c, input logic lvl, input logic trig);
    if (!c.en) return 1'b1;
    if (c.sel) return trig;
    return lvl ^ c.pol;
  endfunction

  function automatic logic mode_diff(input pg_cfg_t a, input pg_cfg_t b);
    return {a.pol, a.sel, a.en} != {b.pol, b.sel, b.en};
  endfunction
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], pin};
      prev <= sh[STAGES-1];
    end
  end

  assign lvl  = sh[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  // R8: a rise is only reported when the last flop takes a new value
  p_rise_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> $past(sh[STAGES-2]));
endmodule

// File: rtl/pg_mode_ctl.sv
module pg_mode_ctl
  import pg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    we,
  input  pg_cfg_t wdata,
  input  logic    disarm,
  input  logic    lvl,
  input  logic    rise,
  input  logic    fall,
  output pg_cfg_t cfg,
  output logic    trig,
  output logic    run,
  output logic    clr
);
  logic set_evt;

  assign clr     = disarm | (we & mode_diff(wdata, cfg));
  assign set_evt = cfg.en & cfg.sel & act_edge(cfg, rise, fall);
  assign run     = run_ok(cfg, lvl, trig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      trig <= 1'b0;
    end else begin
      if (we) cfg <= wdata;
      if (clr)          trig <= 1'b0;
      else if (set_evt) trig <= 1'b1;
    end
  end

  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !trig);
  p_trig_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !clr) |=> trig);
  p_trig_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) |-> $past(cfg.en && cfg.sel && (rise || fall)));
  p_disabled_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> run);
endmodule

// File: rtl/pg_strobe.sv
module pg_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic xsel,
  input  logic tick,
  input  logic xrise,
  input  logic run,
  output logic pace_evt,
  output logic conv_start
);
  assign pace_evt = xsel ? xrise : tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conv_start <= 1'b0;
    else        conv_start <= pace_evt & run;
  end

  p_strobe_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(run));
  p_tick_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xsel && !xrise) |=> !conv_start);
  p_xpace_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!xsel && !tick) |=> !conv_start);
endmodule

// File: rtl/acq_pace_gate.sv
module acq_pace_gate
  import pg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             disarm,
  input  logic             tg_pin,
  input  logic             xpace_pin,
  input  logic             pacer_tick,
  output logic             tg_din,
  output logic             conv_start,
  output logic             acq_run
);
  localparam int NPIN = 2;
  localparam int TG = 0;
  localparam int XP = 1;

  logic [NPIN-1:0] pins, lvl, rise, fall;
  pg_cfg_t cfg;
  logic trig, run, clr, pace_evt;

  assign pins = {xpace_pin, tg_pin};

  for (genvar i = 0; i < NPIN; i++) begin : g_sync
    pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(pins[i]),
      .lvl(lvl[i]), .rise(rise[i]), .fall(fall[i]));
  end

  pg_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(pg_cfg_t'(cfg_wdata)),
    .disarm(disarm), .lvl(lvl[TG]), .rise(rise[TG]), .fall(fall[TG]),
    .cfg(cfg), .trig(trig), .run(run), .clr(clr));

  pg_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .xsel(cfg.xsel), .tick(pacer_tick),
    .xrise(rise[XP]), .run(run), .pace_evt(pace_evt), .conv_start(conv_start));

  assign tg_din  = lvl[TG];
  assign acq_run = run;

  p_one_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !pace_evt) |=> !conv_start);
  p_gate_no_rearm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && !cfg.sel && !cfg_we && $rose(tg_din) && !cfg.pol) |-> acq_run);
endmodule

// File: tb/tb_acq_pace_gate.sv
module tb_acq_pace_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, dis = 1'b0, tg = 1'b0, xp = 1'b0, tk = 1'b0;
  logic [3:0] wd = '0;
  logic din, cs, run;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  acq_pace_gate dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_wdata(wd), .disarm(dis),
    .tg_pin(tg), .xpace_pin(xp), .pacer_tick(tk),
    .tg_din(din), .conv_start(cs), .acq_run(run));

  // reference model, written from the requirements
  logic t1, t2, tp, x1, x2, xpv, m_trig, m_cs;
  logic [3:0] m_cfg;
  logic [2:0] expq[$];

  always @(posedge clk) begin
    logic act, r_old, evt, clear;
    if (!rst_n) begin
      {t1, t2, tp, x1, x2, xpv, m_trig, m_cs} = '0;
      m_cfg = '0;
    end else begin
      act   = m_cfg[2] ? (!t2 && tp) : (t2 && !tp);
      r_old = !m_cfg[0] ? 1'b1 : (m_cfg[1] ? m_trig : (t2 != m_cfg[2]));
      evt   = m_cfg[3] ? (x2 && !xpv) : tk;
      clear = dis || (we && (wd[2:0] != m_cfg[2:0]));
      m_cs  = evt && r_old;
      if (clear) m_trig = 1'b0;
      else if (m_cfg[0] && m_cfg[1] && act) m_trig = 1'b1;
      if (we) m_cfg = wd;
      tp = t2; t2 = t1; t1 = tg;
      xpv = x2; x2 = x1; x1 = xp;
      r_old = !m_cfg[0] ? 1'b1 : (m_cfg[1] ? m_trig : (t2 != m_cfg[2]));
      expq.push_back({m_cs, r_old, t2});
    end
  end

  // monitor
  always @(negedge clk) begin
    logic [2:0] e;
    if (rst_n && expq.size() > 0) begin
      e = expq.pop_front();
      vectors++;
      if ({cs, run, din} !== e) begin
        miscompares++;
        $display("FAIL %s: {conv_start,acq_run,tg_din} act=%b exp=%b at %0t",
                 cur_req, {cs, run, din}, e, $time);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(logic [3:0] v);
    we = 1'b1; wd = v; step(); we = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tk = 1'b1; step(); tk = 1'b0; step(); end
  endtask

  task automatic xpulses(int n);
    for (int i = 0; i < n; i++) begin xp = 1'b1; step(3); xp = 1'b0; step(3); end
  endtask

  task automatic direct(string tag, logic got, logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: act=%b exp=%b", tag, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1 reset state
    #13;
    direct("R1 conv_start in reset", cs, 1'b0);
    direct("R1 acq_run in reset", run, 1'b1);
    @(posedge clk); #2; rst_n = 1'b1;
    step(3);

    // R2 disabled: pin has no effect, tg_din follows after two clocks
    cur_req = "R2";
    ticks(3);
    tg = 1'b1; step(2);
    direct("R2 tg_din after two clocks", din, 1'b1);
    direct("R2 acq_run ignores pin", run, 1'b1);
    ticks(2); tg = 1'b0; step(4); ticks(2);

    // R3 gate, active high then active low
    cur_req = "R3";
    wr(4'b0001); step(3); ticks(3);
    tg = 1'b1; step(3); ticks(3);
    tg = 1'b0; step(3); ticks(2);
    tg = 1'b1; step(3); ticks(2);
    wr(4'b0101); step(3); ticks(3);
    tg = 1'b0; step(3); ticks(3);

    // R4 trigger, rising: start, then pin ignored
    cur_req = "R4";
    wr(4'b0011); step(3); ticks(2);
    tg = 1'b1; tk = 1'b1; step(3); tk = 1'b0; step();
    direct("R4 run after rising edge", run, 1'b1);
    ticks(2); tg = 1'b0; step(4); ticks(2); tg = 1'b1; step(4); ticks(1);

    // R5 rewrite same mode keeps run; disarm clears
    cur_req = "R5";
    wr(4'b0011); step(2);
    direct("R5 same-value write keeps trigger", run, 1'b1);
    dis = 1'b1; step(); dis = 1'b0; step();
    direct("R5 disarm clears trigger", run, 1'b0);
    ticks(2);
    // disarm coincident with edge detection
    tg = 1'b0; step(4); tg = 1'b1; step(2); dis = 1'b1; step(); dis = 1'b0; step(2);
    direct("R5 disarm beats same-cycle edge", run, 1'b0);
    ticks(2);

    // R4 falling-edge trigger
    cur_req = "R4";
    wr(4'b0111); step(4); ticks(1);
    tg = 1'b0; step(4);
    direct("R4 run after falling edge", run, 1'b1);
    ticks(2);

    // R5 mode-changing write coincident with edge
    cur_req = "R5";
    wr(4'b0011); step(2);
    tg = 1'b1; step(2); wr(4'b0111); step(2);
    direct("R5 mode write beats same-cycle edge", run, 1'b0);
    tg = 1'b0; step(4); ticks(1);

    // R7 external pacing with gate and disabled modes
    cur_req = "R7";
    wr(4'b1000); step(3); ticks(3); xpulses(3);
    wr(4'b1001); step(3); xpulses(2);
    tg = 1'b1; step(3); xpulses(2); ticks(2);
    tg = 1'b0; wr(4'b1011); step(3); xpulses(1);
    tg = 1'b1; step(4); xpulses(2);

    // R6/R8 mixed stimulus
    cur_req = "R6";
    for (int i = 0; i < 400; i++) begin
      tk = $urandom_range(0, 1);
      tg = ($urandom_range(0, 5) == 0) ? ~tg : tg;
      xp = ($urandom_range(0, 3) == 0) ? ~xp : xp;
      dis = ($urandom_range(0, 40) == 0);
      if ($urandom_range(0, 30) == 0) begin we = 1'b1; wd = 4'($urandom_range(0, 15)); end
      else we = 1'b0;
      step();
    end
    tk = 1'b0; dis = 1'b0; we = 1'b0;
    step(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule